// File: doc/BRIEF.md
# SPI Master Word-FIFO and Status Front End

This block sits between a 32-bit register port and the serial shifter of an SPI master. Software loads words into a 16-entry transmit queue. It programs separate transmit and receive word counts and then sets the run bit. The serial engine takes transmit words through a valid/pop handshake and returns received words through a push/ready handshake. Software drains the receive queue by reading the receive data register.

A small run sequencer has three states. **IDLE**: no transfer. **RUN**: the engine may move words. **DONE**: both counts are exhausted but the run bit is still set. The transitions are IDLE→RUN on a control write with the run bit set. RUN→DONE when both counts are zero. DONE→RUN on a control write with the run bit set, or when a count is reloaded to a nonzero value. RUN→IDLE and DONE→IDLE on a control write with the run bit clear.

Queue events and transfer-complete events are latched into two separate flag registers. Each flag register has its own enable register. A single interrupt line reports any enabled pending flag.

Top module: `spim_front`

## Requirements
- R1: After reset the status register reads 0x0010_0000, both flag registers read 0, and `irq` is low.
- R2: Transmit words leave on `tx_word` in write order. `tx_valid` is high only in RUN, with a nonzero transmit count and a non-empty queue. Each accepted pop decrements the transmit count.
- R3: A write to transmit data (0x08) while the transmit queue holds 16 words drops the word and sets queue flag bit 17.
- R4: A received word is accepted only in RUN, with a nonzero receive count and a queue that is not full. Each accepted word decrements the receive count, and reads of 0x0C return accepted words in order. Other pushes are ignored.
- R5: A read of 0x0C while the receive queue is empty returns 0 and sets queue flag bit 16.
- R6: The status register (0x18) has these fields:
  - transmit full at bit 4
  - transmit level in bits 15:8
  - receive empty at bit 20
  - receive level in bits 31:24
- R7: In the transfer flag register (0x28), bit 1 sets when the pop that takes the transmit count from 1 to 0 happens. Bit 0 sets when the push that takes the receive count from 1 to 0 happens.
- R8: The threshold code in configuration bits 18:17 (0x04) selects the threshold: 0 = 8 words, 1 = 4 words, 2 or 3 = 1 word. Queue flag bit 4 sets while the receive level is at or above the threshold. Queue flag bit 5 sets while the run bit is set, the transmit level is at or below the threshold, and the transmit count exceeds the transmit level.
- R9: Queue flag bit 8 sets while the receive level is 16. Queue flag bit 9 sets while the run bit is set and the transmit queue is empty.
- R10: Writing a flag register (0x20 queue, 0x28 transfer) clears the flags whose data bits are 1 and leaves the others. An event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some flag is set together with its enable bit (0x1C for queue flags, 0x24 for transfer flags).
- R12: The control register (0x00) has three bits:
  - bit 0 is run
  - bit 2 empties the transmit queue
  - bit 3 empties the receive queue
  Writing 0 stops the transfer. Emptying a queue does not change any flag. Control reads return the run state in bit 0.
- R13: The sequencer follows the IDLE/RUN/DONE transitions above. Loaded words wait in IDLE, and `xfer_busy` is high only in RUN. Counts load from writes to 0x10 (transmit) and 0x14 (receive) and read back their current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| tx_valid | output | 1 | A transmit word is offered to the engine |
| tx_word | output | WIDTH | Offered transmit word |
| tx_pop | input | 1 | Engine takes the offered word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | WIDTH | Received word |
| rx_ready | output | 1 | A pushed word would be accepted |
| xfer_busy | output | 1 | Sequencer is in RUN |
| irq | output | 1 | Any enabled pending flag |

## Verification
A transmit stream is loaded before the run bit is set. The stream is replayed against a scoreboard queue, which separates ordering faults from count and gating faults. A second stream is started with the engine stalled. This exposes the threshold and empty flags while words are still pending, and shows that loaded words wait in IDLE until run is set again. Receive traffic is applied at threshold codes 1 and 2 and up to a full queue. This separates the threshold comparison from the full flag and from pushes ignored with a zero count. Overfilling, over-reading and queue resets check that dropped words stay dropped and that latched flags survive a queue reset.

// File: rtl/spim_front_pkg.sv
package spim_front_pkg;

    // Register byte offsets
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CFG   = 8'h04;
    localparam logic [7:0] OFF_TXD   = 8'h08;
    localparam logic [7:0] OFF_RXD   = 8'h0C;
    localparam logic [7:0] OFF_TXCNT = 8'h10;
    localparam logic [7:0] OFF_RXCNT = 8'h14;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_QEN   = 8'h1C;
    localparam logic [7:0] OFF_QFLG  = 8'h20;
    localparam logic [7:0] OFF_XEN   = 8'h24;
    localparam logic [7:0] OFF_XFLG  = 8'h28;

    // Queue-event flag positions
    localparam int QF_RX_THR  = 4;
    localparam int QF_TX_THR  = 5;
    localparam int QF_RX_FULL = 8;
    localparam int QF_TX_EMPT = 9;
    localparam int QF_RX_UND  = 16;
    localparam int QF_TX_OVF  = 17;

    // Transfer-event flag positions
    localparam int XF_RX_DONE = 0;
    localparam int XF_TX_DONE = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_st_e;

    function automatic int unsigned thr_words(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/spim_word_fifo.sv
module spim_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/spim_flag_bank.sv
module spim_flag_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         flag_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flag_q,
    output logic         hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set[i] | (flag_q[i] & ~(flag_wr & wdata[i]));
        end
    end

    assign hit = |(flag_q & en_q);
endmodule

// File: rtl/spim_run_fsm.sv
module spim_run_fsm
    import spim_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic run_bit,
    input  logic cnt_idle,
    output logic busy,
    output logic active
);
    run_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (ctrl_wr && run_bit) st_d = ST_RUN;
            ST_RUN: begin
                if (ctrl_wr && !run_bit) st_d = ST_IDLE;
                else if (cnt_idle)       st_d = ST_DONE;
            end
            ST_DONE: begin
                if (ctrl_wr && !run_bit)                st_d = ST_IDLE;
                else if ((ctrl_wr && run_bit) || !cnt_idle) st_d = ST_RUN;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        busy   = 1'b0;
        active = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RUN:  begin busy = 1'b1; active = 1'b1; end
            ST_DONE: active = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/spim_front.sv
module spim_front
    import spim_front_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    output logic [WIDTH-1:0]  tx_word,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [WIDTH-1:0]  rx_word,
    output logic              rx_ready,
    output logic              xfer_busy,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH + 1);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFF_TXD);
    localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFF_RXD);
    localparam logic [ADDR_W-1:0] A_TXCNT = ADDR_W'(OFF_TXCNT);
    localparam logic [ADDR_W-1:0] A_RXCNT = ADDR_W'(OFF_RXCNT);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_QEN   = ADDR_W'(OFF_QEN);
    localparam logic [ADDR_W-1:0] A_QFLG  = ADDR_W'(OFF_QFLG);
    localparam logic [ADDR_W-1:0] A_XEN   = ADDR_W'(OFF_XEN);
    localparam logic [ADDR_W-1:0] A_XFLG  = ADDR_W'(OFF_XFLG);

    // Register strobes
    logic wr_ctrl, wr_cfg, wr_txd, wr_txcnt, wr_rxcnt;
    logic wr_qen, wr_qflg, wr_xen, wr_xflg, rd_rxd;
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_cfg   = reg_wr && (reg_addr == A_CFG);
    assign wr_txd   = reg_wr && (reg_addr == A_TXD);
    assign wr_txcnt = reg_wr && (reg_addr == A_TXCNT);
    assign wr_rxcnt = reg_wr && (reg_addr == A_RXCNT);
    assign wr_qen   = reg_wr && (reg_addr == A_QEN);
    assign wr_qflg  = reg_wr && (reg_addr == A_QFLG);
    assign wr_xen   = reg_wr && (reg_addr == A_XEN);
    assign wr_xflg  = reg_wr && (reg_addr == A_XFLG);
    assign rd_rxd   = reg_rd && (reg_addr == A_RXD);

    // Sequencer
    logic [31:0] tx_cnt, rx_cnt;
    logic        active;
    spim_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (wr_ctrl),
        .run_bit  (reg_wdata[0]),
        .cnt_idle ((tx_cnt == '0) && (rx_cnt == '0)),
        .busy     (xfer_busy),
        .active   (active)
    );

    // Queues
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [WIDTH-1:0] rx_dout;
    logic             tx_take, rx_take;

    assign tx_valid = xfer_busy && (tx_cnt != '0) && !tx_empty;
    assign tx_take  = tx_valid && tx_pop;
    assign rx_ready = xfer_busy && (rx_cnt != '0) && !rx_full;
    assign rx_take  = rx_push && rx_ready;

    spim_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ctrl && reg_wdata[2]),
        .push  (wr_txd),
        .din   (reg_wdata[WIDTH-1:0]),
        .pop   (tx_take),
        .dout  (tx_word),
        .level (tx_lvl),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ctrl && reg_wdata[3]),
        .push  (rx_take),
        .din   (rx_word),
        .pop   (rd_rxd),
        .dout  (rx_dout),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Counters and configuration
    logic [1:0] thr_code;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt   <= '0;
            rx_cnt   <= '0;
            thr_code <= '0;
        end else begin
            if (wr_txcnt)     tx_cnt <= reg_wdata;
            else if (tx_take) tx_cnt <= tx_cnt - 1'b1;
            if (wr_rxcnt)     rx_cnt <= reg_wdata;
            else if (rx_take) rx_cnt <= rx_cnt - 1'b1;
            if (wr_cfg)       thr_code <= reg_wdata[18:17];
        end
    end

    // Event detection
    logic [LW-1:0] thr;
    logic [31:0]   q_set, x_set;
    assign thr = LW'(thr_words(thr_code));

    always_comb begin
        q_set             = '0;
        q_set[QF_RX_THR]  = (rx_lvl >= thr);
        q_set[QF_TX_THR]  = active && (tx_lvl <= thr) && (tx_cnt > 32'(tx_lvl));
        q_set[QF_RX_FULL] = rx_full;
        q_set[QF_TX_EMPT] = active && tx_empty;
        q_set[QF_RX_UND]  = rd_rxd && rx_empty;
        q_set[QF_TX_OVF]  = wr_txd && tx_full;
        x_set             = '0;
        x_set[XF_RX_DONE] = rx_take && (rx_cnt == 32'd1);
        x_set[XF_TX_DONE] = tx_take && (tx_cnt == 32'd1);
    end

    logic [31:0] qen, qflags, xen, xflags;
    logic        q_hit, x_hit;

    spim_flag_bank #(.W(32)) u_qflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (wr_qen),
        .flag_wr (wr_qflg),
        .wdata   (reg_wdata),
        .set     (q_set),
        .en_q    (qen),
        .flag_q  (qflags),
        .hit     (q_hit)
    );

    spim_flag_bank #(.W(32)) u_xflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (wr_xen),
        .flag_wr (wr_xflg),
        .wdata   (reg_wdata),
        .set     (x_set),
        .en_q    (xen),
        .flag_q  (xflags),
        .hit     (x_hit)
    );

    assign irq = q_hit || x_hit;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = {31'b0, active};
            A_CFG:   reg_rdata = {13'b0, thr_code, 17'b0};
            A_RXD:   reg_rdata = rx_empty ? 32'b0 : 32'(rx_dout);
            A_TXCNT: reg_rdata = tx_cnt;
            A_RXCNT: reg_rdata = rx_cnt;
            A_STAT:  reg_rdata = {8'(rx_lvl), 3'b0, rx_empty, 4'b0,
                                  8'(tx_lvl), 3'b0, tx_full, 4'b0};
            A_QEN:   reg_rdata = qen;
            A_QFLG:  reg_rdata = qflags;
            A_XEN:   reg_rdata = xen;
            A_XFLG:  reg_rdata = xflags;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_front_chk.sv
module spim_front_chk
    import spim_front_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6,
    parameter int LW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              tx_valid,
    input logic              tx_pop,
    input logic              xfer_busy,
    input logic [LW-1:0]     tx_lvl,
    input logic [31:0]       tx_cnt,
    input logic [31:0]       qflags,
    input logic [31:0]       xflags
);
    logic wr_txd, wr_ctrl, clr_ovf;
    assign wr_txd  = reg_wr && (reg_addr == ADDR_W'(OFF_TXD));
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign clr_ovf = reg_wr && (reg_addr == ADDR_W'(OFF_QFLG)) && reg_wdata[QF_TX_OVF];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_lvl == LW'(DEPTH)) |=> qflags[QF_TX_OVF]);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl <= LW'(DEPTH));

    // R2
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (xfer_busy && tx_cnt != '0));

    // R12
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[2]) |=> (tx_lvl == '0));

    // R7
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_pop && tx_cnt == 32'd1) |=> xflags[XF_TX_DONE]);

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qflags[QF_TX_OVF] && !clr_ovf) |=> qflags[QF_TX_OVF]);
endmodule

bind spim_front spim_front_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LW(LW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_valid  (tx_valid),
    .tx_pop    (tx_pop),
    .xfer_busy (xfer_busy),
    .tx_lvl    (tx_lvl),
    .tx_cnt    (tx_cnt),
    .qflags    (qflags),
    .xflags    (xflags)
);

// File: tb/spim_front_tb_top.sv
module spim_front_tb_top;
    localparam logic [5:0] CTRL = 6'h00, CFG = 6'h04, TXD = 6'h08, RXD = 6'h0C;
    localparam logic [5:0] TXC = 6'h10, RXC = 6'h14, FST = 6'h18;
    localparam logic [5:0] QEN = 6'h1C, QFL = 6'h20, XEN = 6'h24, XFL = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_valid, tx_pop = 1'b0;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_ready, xfer_busy, irq;

    always #10 clk = ~clk;

    spim_front dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .rx_ready(rx_ready),
        .xfer_busy(xfer_busy), .irq(irq)
    );

    int          n_chk = 0, n_bad = 0;
    logic [31:0] tx_exp[$];
    logic [31:0] rx_exp[$];
    logic        eng_en = 1'b0;
    logic [31:0] v;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic push_tx(input logic [31:0] w);
        tx_exp.push_back(w);
        wr(TXD, w);
    endtask

    task automatic push_rx(input logic [31:0] w, input bit accepted);
        if (accepted) rx_exp.push_back(w);
        @(negedge clk); rx_push = 1'b1; rx_word = w;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic pull_rx(input string req);
        logic [31:0] d;
        rd(RXD, d);
        if (rx_exp.size() == 0) chk(req, d, 32'h0);
        else chk(req, d, rx_exp.pop_front());
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Transmit-side monitor: pops and compares against the scoreboard
    initial forever begin
        @(negedge clk);
        if (eng_en && tx_valid) begin
            n_chk++;
            if (tx_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected word actual=%h expected=none", tx_word);
            end else begin
                logic [31:0] e;
                e = tx_exp.pop_front();
                if (tx_word !== e) begin
                    n_bad++;
                    $display("FAIL R2 order actual=%h expected=%h", tx_word, e);
                end
            end
            tx_pop = 1'b1;
        end else begin
            tx_pop = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, R6 layout
        rd(FST, v); chk("R1 status", v, 32'h0010_0000);
        rd(QFL, v); chk("R1 queue flags", v, 0);
        rd(XFL, v); chk("R1 transfer flags", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 stream loaded before run
        wr(TXC, 5);
        for (int i = 0; i < 5; i++) push_tx(32'hA000_0000 + i);
        rd(FST, v); chk("R6 tx level 5", v, 32'h0010_0500);
        eng_en = 1'b1;
        wr(CTRL, 1);
        idle(12);
        chk("R2 stream drained", tx_exp.size(), 0);
        rd(TXC, v); chk("R13 tx count read", v, 0);
        rd(XFL, v); chk("R7 tx complete", v, 32'h2);
        rd(QFL, v); chk("R9 tx empty only", v, 32'h200);
        rd(CTRL, v); chk("R12 run readback", v, 1);

        // R3 overflow
        wr(CTRL, 0);
        wr(XFL, 32'hFFFF_FFFF);
        wr(QFL, 32'hFFFF_FFFF);
        rd(QFL, v); chk("R10 all cleared", v, 0);
        for (int i = 0; i < 16; i++) wr(TXD, 32'hB000_0000 + i);
        wr(TXD, 32'h0000_DEAD);
        rd(FST, v); chk("R6 tx full", v, 32'h0010_1010);
        rd(QFL, v); chk("R3 overflow flag", v, 32'h2_0000);

        // R12 reset keeps flags
        wr(CTRL, 4);
        rd(FST, v); chk("R12 tx flush level", v, 32'h0010_0000);
        rd(QFL, v); chk("R12 flags kept", v, 32'h2_0000);

        // R8 threshold code 1, engine stalled
        eng_en = 1'b0;
        wr(CFG, 32'h1 << 17);
        wr(TXC, 6);
        push_tx(32'hC000_0000);
        push_tx(32'hC000_0001);
        wr(CTRL, 1);
        idle(2);
        rd(QFL, v); chk("R8 tx threshold", v, 32'h2_0020);
        eng_en = 1'b1;
        idle(6);
        chk("R2 partial drain", tx_exp.size(), 0);
        for (int i = 2; i < 6; i++) push_tx(32'hC000_0000 + i);
        idle(10);
        chk("R2 second stream drained", tx_exp.size(), 0);
        rd(XFL, v); chk("R7 tx complete again", v, 32'h2);

        // R4 receive path
        wr(CTRL, 0);
        wr(XFL, 32'hFFFF_FFFF);
        wr(QFL, 32'hFFFF_FFFF);
        push_rx(32'hD9D9_D9D9, 1'b0);
        rd(FST, v); chk("R4 push ignored when idle", v, 32'h0010_0000);
        wr(RXC, 4);
        wr(CTRL, 1);
        for (int i = 0; i < 3; i++) push_rx(32'hD000_0000 + i, 1'b1);
        rd(QFL, v); chk("R8 rx below threshold", v & 32'h10, 0);
        push_rx(32'hD000_0003, 1'b1);
        rd(QFL, v); chk("R8 rx at threshold", v & 32'h10, 32'h10);
        rd(FST, v); chk("R6 rx level 4", v, 32'h0400_0000);
        for (int i = 0; i < 4; i++) pull_rx("R4 rx order");
        rd(XFL, v); chk("R7 rx complete", v, 32'h1);
        rd(RXD, v); chk("R5 underrun data", v, 0);
        rd(QFL, v); chk("R5 underrun flag", v & 32'h1_0000, 32'h1_0000);
        push_rx(32'hEEEE_EEEE, 1'b0);
        rd(FST, v); chk("R4 push ignored at zero count", v, 32'h0010_0000);

        // R11 interrupt, R10 write-one-to-clear
        chk("R11 irq without enable", {31'b0, irq}, 0);
        wr(XEN, 1);
        chk("R11 irq enabled", {31'b0, irq}, 1);
        wr(XFL, 0);
        rd(XFL, v); chk("R10 zero write keeps", v, 1);
        wr(XFL, 1);
        chk("R11 irq after clear", {31'b0, irq}, 0);
        wr(XEN, 0);

        // R13 words wait while idle
        wr(CTRL, 0);
        chk("R13 busy idle", {31'b0, xfer_busy}, 0);
        wr(TXC, 2);
        push_tx(32'hE000_0000);
        idle(5);
        chk("R13 held in idle", tx_exp.size(), 1);
        wr(CTRL, 1);
        idle(5);
        chk("R13 released by run", tx_exp.size(), 0);
        chk("R13 busy in run", {31'b0, xfer_busy}, 1);
        push_tx(32'hE000_0001);
        idle(5);
        chk("R13 done not busy", {31'b0, xfer_busy}, 0);

        // R8 threshold code 2, R9 receive full, R12 rx flush
        wr(CTRL, 0);
        wr(CFG, 32'h2 << 17);
        wr(QFL, 32'hFFFF_FFFF);
        wr(RXC, 17);
        wr(CTRL, 1);
        push_rx(32'hF000_0000, 1'b1);
        rd(QFL, v); chk("R8 rx one word threshold", v & 32'h10, 32'h10);
        for (int i = 1; i < 16; i++) push_rx(32'hF000_0000 + i, 1'b1);
        rd(QFL, v); chk("R9 rx full", v & 32'h100, 32'h100);
        rd(FST, v); chk("R6 rx level 16", v, 32'h1000_0000);
        chk("R4 not ready when full", {31'b0, rx_ready}, 0);
        push_rx(32'hF0F0_F0F0, 1'b0);
        pull_rx("R4 first after full");
        wr(CTRL, 8);
        rx_exp.delete();
        rd(FST, v); chk("R12 rx flush", v, 32'h0010_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule